// File: doc/BRIEF.md
# SPI Master with Readback Dummy Byte

This block is a single-master serial peripheral controller that talks to several slave devices, each reached through its own active-low select line. A host pulses `start` together with a slave index, a byte count, a select-to-clock wait length and a readback flag. The controller pulls the chosen select low, puts the first data bit on MOSI, waits, and then clocks bytes out and in at the same time, most significant bit first.

Many slaves answer one byte late, so the byte they return for the final transmitted byte would otherwise be lost. With readback enabled, the controller appends one extra byte of all ones after the last transmit byte. The slave's last reply is shifted in during that byte and reported like any other received byte.

Transmit bytes are taken from `tx_data` when the transaction starts and again at each byte boundary. `tx_taken` pulses each time a byte is taken, so the host can present the next one. Received bytes appear on `rx_data` with a one-cycle `rx_valid` pulse.

Top module: `spi_rb_master`

## Requirements
- R1: While idle every select line is high. During a transaction exactly the line numbered by `slave_idx` (sampled at start) is low and it does not change until release.
- R2: The first rising edge of `sclk` comes exactly `wait_len + HALF_DIV` system clocks after the select line goes low. MOSI carries the first byte's MSB from the moment select goes low.
- R3: `sclk` is low whenever the block is not busy. During a transaction every high phase and every low phase between rising edges lasts exactly `HALF_DIV` system clocks.
- R4: MOSI never changes in the cycle where `sclk` rises. Data goes out MSB first.
- R5: MISO is sampled on each falling edge of `sclk` and assembled MSB first. `rx_valid` pulses for one cycle, together with the falling edge that completes a byte, and `rx_data` then holds that byte.
- R6: Exactly `byte_count` bytes are transmitted, and a count of 0 is treated as 1. `tx_data` is taken at start and at each byte boundary, with one `tx_taken` pulse per byte taken.
- R7: With `readback_en` set at start, one extra byte of 0xFF follows the last transmit byte, and its received byte is reported with `rx_valid`. With `readback_en` clear no extra byte is sent.
- R8: Select returns high exactly `HALF_DIV` system clocks after the last falling edge of `sclk`. `busy` clears on the cycle after that.
- R9: A `start` pulse while `busy` is high is ignored. The select, byte count and clock sequence of the running transaction are unaffected.
- R10: After reset, all selects are high, `sclk`, `mosi`, `busy`, `rx_valid` and `tx_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start strobe, one cycle |
| slave_idx | input | $clog2(NUM_SLAVES) | Slave to select |
| byte_count | input | CNT_W | Number of transmit bytes (0 means 1) |
| wait_len | input | WAIT_W | Extra system clocks between select low and the first clock |
| readback_en | input | 1 | Append a trailing 0xFF byte to read the last reply |
| tx_data | input | 8 | Transmit byte presented by the host |
| tx_taken | output | 1 | Pulses when `tx_data` has been taken |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulses once per received byte |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SLAVES | Active-low select lines |

## Verification
Two things can fall in the same cycle. At a byte boundary, the falling edge that completes a byte also reports that byte on `rx_valid` and reloads the shift register, either with the next `tx_data` or with the dummy pattern. The bench provokes this with an echoing slave model that returns each byte one byte late, in multi-byte runs with and without readback. It judges the outcome by comparing every received byte and every byte the slave captured against the expected sequence, so a lost or doubled bit at a boundary shows up as a wrong byte. The second case is a `start` that arrives mid-transaction while the shifter is busy. It is judged by watching that no other select line ever drops and that the byte and edge counts stay those of the running transaction.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_DONE
  } spi_state_e;

  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

endpackage

// File: rtl/spi_rb_timer.sv
module spi_rb_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3: a freshly loaded nonzero count is never reported as expired
  a_r3_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       miso_bit,
  output logic [7:0] data,
  output logic [7:0] shifted,
  output logic       last_bit
);

  logic [7:0] data_q;
  logic [7:0] data_d;
  logic [2:0] bit_q;
  logic [2:0] bit_d;

  assign shifted = {data_q[6:0], miso_bit};

  always_comb begin
    data_d = data_q;
    bit_d  = bit_q;
    if (load) begin
      data_d = load_byte;
      bit_d  = 3'd0;
    end else if (shift) begin
      data_d = shifted;
      bit_d  = bit_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit_q  <= '0;
    end else begin
      data_q <= data_d;
      bit_q  <= bit_d;
    end
  end

  assign data     = data_q;
  assign last_bit = (bit_q == 3'd7);

  // R4: a shift without reload moves the old bit 6 into the MSB position
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (data_q[7] == $past(data_q[6])));

endmodule

// File: rtl/spi_rb_select.sv
module spi_rb_select #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grab,
  input  logic          drop,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  ss_n
);

  logic [N-1:0] ss_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic line_d;
    always_comb begin
      line_d = ss_q[i];
      if (grab)      line_d = (idx != IW'(i));
      else if (drop) line_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ss_q[i] <= 1'b1;
      else        ss_q[i] <= line_d;
    end
  end

  assign ss_n = ss_q;

  // R1: a grab lowers exactly the indexed line
  a_r1_grab_target: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> (ss_q[$past(idx)] == 1'b0) && ($countones(~ss_q) == 1));

endmodule

// File: rtl/spi_rb_master.sv
module spi_rb_master
  import spi_rb_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int HALF_DIV   = 2,
  parameter int WAIT_W     = 8,
  parameter int CNT_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(NUM_SLAVES)-1:0] slave_idx,
  input  logic [CNT_W-1:0]              byte_count,
  input  logic [WAIT_W-1:0]             wait_len,
  input  logic                          readback_en,
  input  logic [7:0]                    tx_data,
  output logic                          tx_taken,
  output logic [7:0]                    rx_data,
  output logic                          rx_valid,
  output logic                          busy,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso,
  output logic [NUM_SLAVES-1:0]         ss_n
);

  localparam int IDX_W = $clog2(NUM_SLAVES);
  localparam int HW    = $clog2(HALF_DIV + 1);
  localparam int TW    = ((WAIT_W > HW) ? WAIT_W : HW) + 1;
  localparam logic [TW-1:0] HALF_M1 = TW'(HALF_DIV - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // state
  spi_state_e       st_q, st_d;
  logic             sclk_q, sclk_d;
  logic [CNT_W-1:0] bytes_q, bytes_d;
  logic             rb_q, rb_d;
  logic             dummy_q, dummy_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             rxv_q, rxv_d;
  logic             take_q, take_d;

  // sub-block controls
  logic          tm_load, tm_exp;
  logic [TW-1:0] tm_val;
  logic          sh_load, sh_shift, sh_last;
  logic [7:0]    sh_val, sh_data, sh_next;
  logic          sel_grab, sel_drop;
  logic          sel_active;

  spi_rb_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  spi_rb_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (sh_load),
    .load_byte (sh_val),
    .shift     (sh_shift),
    .miso_bit  (miso),
    .data      (sh_data),
    .shifted   (sh_next),
    .last_bit  (sh_last)
  );

  spi_rb_select #(.N(NUM_SLAVES), .IW(IDX_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_i_n),
    .grab  (sel_grab),
    .drop  (sel_drop),
    .idx   (slave_idx),
    .ss_n  (ss_n)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    sclk_d   = sclk_q;
    bytes_d  = bytes_q;
    rb_d     = rb_q;
    dummy_d  = dummy_q;
    rxd_d    = rxd_q;
    rxv_d    = 1'b0;
    take_d   = 1'b0;
    tm_load  = 1'b0;
    tm_val   = HALF_M1;
    sh_load  = 1'b0;
    sh_val   = tx_data;
    sh_shift = 1'b0;
    sel_grab = 1'b0;
    sel_drop = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          sel_grab = 1'b1;
          sh_load  = 1'b1;
          take_d   = 1'b1;
          tm_load  = 1'b1;
          tm_val   = TW'(wait_len) + HALF_M1;
          bytes_d  = (byte_count == '0) ? CNT_W'(1) : byte_count;
          rb_d     = readback_en;
          dummy_d  = 1'b0;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT, ST_LOW: begin
        if (tm_exp) begin
          sclk_d  = 1'b1;
          tm_load = 1'b1;
          st_d    = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tm_exp) begin
          sclk_d   = 1'b0;
          tm_load  = 1'b1;
          sh_shift = 1'b1;
          st_d     = ST_LOW;
          if (sh_last) begin
            rxv_d = 1'b1;
            rxd_d = sh_next;
            if (bytes_q > CNT_W'(1)) begin
              bytes_d = bytes_q - 1'b1;
              sh_load = 1'b1;
              take_d  = 1'b1;
            end else if (rb_q && !dummy_q) begin
              dummy_d = 1'b1;
              sh_load = 1'b1;
              sh_val  = DUMMY_BYTE;
            end else begin
              st_d = ST_TAIL;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tm_exp) begin
          sel_drop = 1'b1;
          st_d     = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      sclk_q  <= 1'b0;
      bytes_q <= '0;
      rb_q    <= 1'b0;
      dummy_q <= 1'b0;
      rxd_q   <= '0;
      rxv_q   <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sclk_q  <= sclk_d;
      bytes_q <= bytes_d;
      rb_q    <= rb_d;
      dummy_q <= dummy_d;
      rxd_q   <= rxd_d;
      rxv_q   <= rxv_d;
      take_q  <= take_d;
    end
  end

  assign sel_active = ~&ss_n;
  assign busy       = (st_q != ST_IDLE);
  assign sclk       = sclk_q;
  assign mosi       = sel_active & sh_data[7];
  assign rx_data    = rxd_q;
  assign rx_valid   = rxv_q;
  assign tx_taken   = take_q;

  // R1: a select line is low only inside a transaction
  a_r1_sel_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    sel_active |-> busy);

  // R2: no clock edge during the select-to-clock wait
  a_r2_wait_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_WAIT) |-> !sclk);

  // R3: serial clock idles low
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !sclk);

  // R4: MOSI held across each rising edge
  a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(sclk) |-> $stable(mosi));

  // R5: a received byte is reported together with a falling edge
  a_r5_valid_fall: assert property (@(posedge clk) disable iff (!rst_i_n)
    rx_valid |-> $fell(sclk));

  // R8: busy clears only after select has already been high for a cycle
  a_r8_busy_after_release: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(busy) |-> (&ss_n && $past(&ss_n)));

  // R9: the selection of a running transaction does not move
  a_r9_sel_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_active && $past(sel_active)) |-> $stable(ss_n));

endmodule

// File: tb/spi_rb_master_test.sv
module spi_rb_master_test;

  localparam int NS   = 4;
  localparam int HALF = 2;
  localparam int WW   = 8;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    slave_idx = '0;
  logic [CW-1:0] byte_count = '0;
  logic [WW-1:0] wait_len = '0;
  logic          readback_en = 1'b0;
  logic [7:0]    tx_data = '0;
  logic          tx_taken;
  logic [7:0]    rx_data;
  logic          rx_valid;
  logic          busy;
  logic          sclk;
  logic          mosi;
  logic          miso_r = 1'b0;
  logic [NS-1:0] ss_n;

  always #10 clk = ~clk;

  spi_rb_master #(.NUM_SLAVES(NS), .HALF_DIV(HALF), .WAIT_W(WW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .slave_idx(slave_idx),
    .byte_count(byte_count), .wait_len(wait_len), .readback_en(readback_en),
    .tx_data(tx_data), .tx_taken(tx_taken), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso_r), .ss_n(ss_n)
  );

  int checks = 0;
  int failures = 0;

  logic [7:0] tx_bytes [8];
  logic [7:0] rx_q [16];
  logic [7:0] s_rx [16];
  int rx_cnt, s_cnt, take_cnt, tx_ptr;
  int exp_idx;
  int sel_err, hi_err, lo_err, mosi_err, rise_cnt;
  int low_run, high_run, first_wait, tail_len, busy_after;
  bit first_pending, rel_flag, prev_sclk, prev_sel, prev_mosi;

  // slave model: echoes each byte one byte late, first reply 0xA5
  logic [7:0] s_in, s_out;
  int s_bits;
  always @(posedge sclk) begin
    if (ss_n[exp_idx] == 1'b0) begin
      s_in   = {s_in[6:0], mosi};
      miso_r = s_out[7 - s_bits];
      s_bits = s_bits + 1;
      if (s_bits == 8) begin
        if (s_cnt < 16) s_rx[s_cnt] = s_in;
        s_cnt  = s_cnt + 1;
        s_out  = s_in;
        s_bits = 0;
      end
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rel_flag) begin
        busy_after = int'(busy);
        rel_flag   = 1'b0;
      end
      if (rx_valid) begin
        if (rx_cnt < 16) rx_q[rx_cnt] = rx_data;
        rx_cnt = rx_cnt + 1;
      end
      if (tx_taken) begin
        take_cnt = take_cnt + 1;
        tx_ptr   = tx_ptr + 1;
        tx_data  = tx_bytes[tx_ptr % 8];
      end
      if (~&ss_n) begin
        if ($countones(~ss_n) != 1 || ss_n[exp_idx] != 1'b0) sel_err = sel_err + 1;
        if (sclk) begin
          if (!prev_sclk) begin
            rise_cnt = rise_cnt + 1;
            if (mosi != prev_mosi) mosi_err = mosi_err + 1;
            if (first_pending) begin
              first_wait    = low_run;
              first_pending = 1'b0;
            end else if (low_run != HALF) begin
              lo_err = lo_err + 1;
            end
            low_run = 0;
          end
          high_run = high_run + 1;
        end else begin
          if (prev_sclk) begin
            if (high_run != HALF) hi_err = hi_err + 1;
            high_run = 0;
          end
          low_run = low_run + 1;
        end
      end else if (prev_sel) begin
        tail_len = low_run;
        low_run  = 0;
        rel_flag = 1'b1;
      end
      if (!busy && sclk) hi_err = hi_err + 1;
      prev_sclk = sclk;
      prev_sel  = ~&ss_n;
      prev_mosi = mosi;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int idx);
    rx_cnt = 0; s_cnt = 0; take_cnt = 0; tx_ptr = 0;
    sel_err = 0; hi_err = 0; lo_err = 0; mosi_err = 0; rise_cnt = 0;
    low_run = 0; high_run = 0; first_wait = -1; tail_len = -1; busy_after = -1;
    first_pending = 1'b1; rel_flag = 1'b0;
    exp_idx = idx;
    s_bits = 0; s_out = 8'hA5; s_in = 8'h00;
  endtask

  task automatic launch(input int idx, input int cnt, input int wl, input bit rb);
    @(negedge clk);
    slave_idx   = 2'(idx);
    byte_count  = CW'(cnt);
    wait_len    = WW'(wl);
    readback_en = rb;
    tx_data     = tx_bytes[0];
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_xfer();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "ss_n in reset", int'(ss_n), 15);
    chk("R10", "sclk in reset", int'(sclk), 0);
    chk("R10", "mosi in reset", int'(mosi), 0);
    chk("R10", "busy in reset", int'(busy), 0);
    chk("R10", "rx_valid/tx_taken in reset", int'(rx_valid) + int'(tx_taken), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "ss_n after release", int'(ss_n), 15);
  endtask

  task automatic test_plain();
    tx_bytes[0] = 8'h3C; tx_bytes[1] = 8'h81; tx_bytes[2] = 8'h5E;
    prep(1);
    launch(1, 3, 0, 1'b0);
    finish_xfer();
    chk("R6", "plain rx byte count", rx_cnt, 3);
    chk("R6", "plain tx_taken count", take_cnt, 3);
    chk("R5", "plain rx[0]", int'(rx_q[0]), 8'hA5);
    chk("R5", "plain rx[1]", int'(rx_q[1]), 8'h3C);
    chk("R5", "plain rx[2]", int'(rx_q[2]), 8'h81);
    chk("R4", "slave got byte0", int'(s_rx[0]), 8'h3C);
    chk("R4", "slave got byte2", int'(s_rx[2]), 8'h5E);
    chk("R7", "no dummy: rising edges", rise_cnt, 24);
    chk("R2", "wait 0 first rise", first_wait, HALF);
    chk("R3", "phase length errors", hi_err + lo_err, 0);
    chk("R4", "mosi change at rise", mosi_err, 0);
    chk("R1", "select errors", sel_err, 0);
    chk("R8", "tail length", tail_len, HALF);
    chk("R8", "busy after release", busy_after, 0);
  endtask

  task automatic test_readback();
    tx_bytes[0] = 8'hD2; tx_bytes[1] = 8'h6B;
    prep(3);
    launch(3, 2, 5, 1'b1);
    finish_xfer();
    chk("R7", "readback rx count", rx_cnt, 3);
    chk("R7", "readback last reply", int'(rx_q[2]), 8'h6B);
    chk("R5", "readback rx[1]", int'(rx_q[1]), 8'hD2);
    chk("R7", "dummy byte seen by slave", int'(s_rx[2]), 8'hFF);
    chk("R6", "readback tx_taken count", take_cnt, 2);
    chk("R2", "wait 5 first rise", first_wait, 5 + HALF);
    chk("R1", "select errors idx3", sel_err, 0);
    chk("R3", "phase errors readback", hi_err + lo_err, 0);
    chk("R8", "tail length readback", tail_len, HALF);
  endtask

  task automatic test_zero_count();
    tx_bytes[0] = 8'h96;
    prep(0);
    launch(0, 0, 1, 1'b0);
    finish_xfer();
    chk("R6", "count 0 rising edges", rise_cnt, 8);
    chk("R6", "count 0 slave byte", int'(s_rx[0]), 8'h96);
    chk("R2", "wait 1 first rise", first_wait, 1 + HALF);
  endtask

  task automatic test_busy_start();
    tx_bytes[0] = 8'h47; tx_bytes[1] = 8'hE1;
    prep(2);
    launch(2, 2, 3, 1'b0);
    repeat (12) @(negedge clk);
    slave_idx  = 2'd0;
    byte_count = CW'(5);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_xfer();
    chk("R9", "select errors with stray start", sel_err, 0);
    chk("R9", "rising edges with stray start", rise_cnt, 16);
    chk("R9", "rx count with stray start", rx_cnt, 2);
    chk("R9", "slave byte1", int'(s_rx[1]), 8'hE1);
    repeat (4) @(negedge clk);
    chk("R9", "still idle afterwards", int'(busy), 0);
    chk("R1", "all selects high afterwards", int'(ss_n), 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    prep(0);
    test_reset();
    test_plain();
    test_readback();
    test_zero_count();
    test_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule